// File: doc/BRIEF.md
# Two-CPU First-Level Interrupt Aggregator

The block gathers a vector of level-sensitive peripheral interrupt lines, grouped into 32-bit words, and drives one interrupt request line to each of two processors. Each processor owns a register bank. The bank holds one read/write enable word per group of 32 sources, followed by the same number of read-only status words that show the live source levels.

A processor's request line is high when at least one source is both active and enabled in that processor's bank. The banks are independent, so software can route a source to one processor and keep it from the other. Access uses a plain 32-bit register port: byte address, write strobe, write data and combinational read data. Status words are laid out in descending group order, so the word at the lowest status offset covers the highest-numbered sources.

Top module: `irq_l1_ctrl`

## Requirements
- R1: The source vector is 32 × NUM_WORDS bits wide. Group g covers sources 32g to 32g+31, and source 32g+b sits in bit b of that group's word.
- R2: Each bank is 8 × NUM_WORDS bytes. Bank c starts at byte c × 8 × NUM_WORDS. The enable words take the first NUM_WORDS word slots of a bank and the status words take the rest. Address bits 1:0 are ignored. With NUM_WORDS=2 the slots are enables at 0x0 and 0x4, status at 0x8 and 0xC, and bank 1 starts at 0x10.
- R3: Word order is descending. Enable slot k holds group NUM_WORDS-1-k, and status slot NUM_WORDS+k holds group NUM_WORDS-1-k. The last slot of each kind holds sources 0 to 31.
- R4: An enable slot is a plain read/write register. A write replaces the whole word, and a read returns the last value written.
- R5: A status slot reads the current level of its 32 sources. Writes to status slots change no register.
- R6: Each processor's output is the registered OR over all bits of (sources AND that bank's enables). It responds on the first rising clock edge after the input or enable change.
- R7: The banks are independent. A write to one bank's enable word leaves the other bank's enables and output unchanged.
- R8: After reset every enable bit is 0, and both outputs stay low whatever the sources do.
- R9: Addresses at or above NUM_CPUS × 8 × NUM_WORDS read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_i | input | 32×NUM_WORDS | Level-sensitive source lines |
| cpu_irq_o | output | NUM_CPUS | Per-processor interrupt request, registered |

## Verification
The bench sets the two source groups to different values and reads both status slots. A design that keeps the groups in ascending order would return the two words swapped. Writes are aimed at a status slot and at an unmapped address, and then every enable is read back. A decoder that lets such writes through would change an enable word or raise an output. Enabling a source in one bank only checks that the other processor's line stays low. Rewriting an enable word with a different bit checks that the write replaces the word rather than ORing into it. Sampling the output in the same cycle as a source change and again one edge later pins down the single register stage.

// File: rtl/irq_l1_pkg.sv
package irq_l1_pkg;
  localparam int SRC_PER_WORD = 32;
  localparam int BYTES_PER_REG = 4;
endpackage

// File: rtl/irq_l1_decode.sv
module irq_l1_decode #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int GRP_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output logic                hit_o,
  output logic                is_en_o,
  output logic [CPU_W-1:0]    bank_o,
  output logic [GRP_W-1:0]    grp_o,
  output logic [NUM_CPUS-1:0] en_we_o
);
  localparam int SLOT_W  = $clog2(2 * NUM_WORDS);
  localparam int BANK_AW = SLOT_W + 2;

  logic [SLOT_W-1:0]         slot;
  logic [ADDR_W-BANK_AW-1:0] bank_idx;
  int                        grp_int;

  assign slot     = addr_i[BANK_AW-1:2];
  assign bank_idx = addr_i[ADDR_W-1:BANK_AW];
  assign hit_o    = (int'(bank_idx) < NUM_CPUS);
  assign is_en_o  = (int'(slot) < NUM_WORDS);
  assign bank_o   = CPU_W'(bank_idx);

  // descending order: lowest slot of each kind carries the top group
  always_comb begin
    if (is_en_o) grp_int = NUM_WORDS - 1 - int'(slot);
    else         grp_int = 2 * NUM_WORDS - 1 - int'(slot);
  end
  assign grp_o = GRP_W'(grp_int);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_we
    assign en_we_o[c] = we_i & hit_o & is_en_o & (int'(bank_idx) == c);
  end
endmodule

// File: rtl/irq_l1_bank.sv
module irq_l1_bank
  import irq_l1_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  localparam int NSRC     = NUM_WORDS * SRC_PER_WORD,
  localparam int GRP_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [GRP_W-1:0]        grp_i,
  input  logic [SRC_PER_WORD-1:0] wdata_i,
  input  logic [NSRC-1:0]         src_i,
  output logic [NSRC-1:0]         en_o,
  output logic                    irq_o
);
  logic [NSRC-1:0] en_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        en_q[w*SRC_PER_WORD +: SRC_PER_WORD] <= '0;
      else if (we_i && (grp_i == GRP_W'(w)))
        en_q[w*SRC_PER_WORD +: SRC_PER_WORD] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(src_i & en_q);
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_l1_ctrl.sv
module irq_l1_ctrl
  import irq_l1_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8,
  localparam int NSRC     = NUM_WORDS * SRC_PER_WORD
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic [SRC_PER_WORD-1:0] wdata_i,
  output logic [SRC_PER_WORD-1:0] rdata_o,
  input  logic [NSRC-1:0]         irq_i,
  output logic [NUM_CPUS-1:0]     cpu_irq_o
);
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int GRP_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int OFS_W = GRP_W + 5;

  logic                         hit, is_en;
  logic [CPU_W-1:0]             bank;
  logic [GRP_W-1:0]             grp;
  logic [NUM_CPUS-1:0]          en_we;
  logic [NUM_CPUS-1:0][NSRC-1:0] en_all;
  logic [OFS_W-1:0]             ofs;

  irq_l1_decode #(
    .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr_i(addr_i), .we_i(we_i), .hit_o(hit), .is_en_o(is_en),
    .bank_o(bank), .grp_o(grp), .en_we_o(en_we)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_l1_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(en_we[c]), .grp_i(grp),
      .wdata_i(wdata_i), .src_i(irq_i), .en_o(en_all[c]), .irq_o(cpu_irq_o[c])
    );
  end

  assign ofs = {grp, 5'b0};

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      if (is_en) rdata_o = en_all[bank][ofs +: SRC_PER_WORD];
      else       rdata_o = irq_i[ofs +: SRC_PER_WORD];
    end
  end
endmodule

// File: rtl/irq_l1_chk.sv
module irq_l1_chk #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      we_i,
  input logic [31:0]               wdata_i,
  input logic [31:0]               rdata_o,
  input logic [32*NUM_WORDS-1:0]   irq_i,
  input logic [NUM_CPUS-1:0]       cpu_irq_o
);
  localparam int BANK_BYTES = 8 * NUM_WORDS;

  int          bank_n, slot_n;
  logic        mapped, en_slot;
  logic [31:0] st_word;

  assign bank_n  = int'(addr_i) / BANK_BYTES;
  assign slot_n  = (int'(addr_i) % BANK_BYTES) / 4;
  assign mapped  = bank_n < NUM_CPUS;
  assign en_slot = slot_n < NUM_WORDS;

  always_comb begin
    st_word = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (w == 2 * NUM_WORDS - 1 - slot_n) st_word = irq_i[w*32 +: 32];
  end

  AST_QUIET_WITHOUT_SOURCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |=> (cpu_irq_o == '0)); // R6

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (rdata_o == '0)); // R9

  AST_STATUS_MIRRORS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mapped && !en_slot) |-> (rdata_o == st_word)); // R3

  AST_ENABLE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i && mapped && en_slot) && !we_i && (addr_i == $past(addr_i)))
      |-> (rdata_o == $past(wdata_i))); // R4
endmodule

bind irq_l1_ctrl irq_l1_chk #(
  .NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_i(irq_i), .cpu_irq_o(cpu_irq_o)
);

// File: tb/sim_irq_l1_ctrl.sv
module sim_irq_l1_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2;
  localparam int NC = 2;
  localparam int AW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [32*NW-1:0]  irq = '0;
  logic [NC-1:0]     cpu_irq;

  irq_l1_ctrl #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .cpu_irq_o(cpu_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_out;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  bit    mon_go = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  // monitor: compares one queued item per flagged cycle, away from the edge
  always @(negedge clk) begin
    if (mon_go && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_out ? 32'(cpu_irq) : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input bit is_out, input logic [31:0] exp, input string tag,
                      input bit wait_edge);
    item_t it;
    if (wait_edge) begin
      @(posedge clk); #1;
    end
    it.is_out = is_out; it.exp = exp; it.tag = tag;
    q.push_back(it);
    mon_go = 1;
    @(posedge clk); #1;
    mon_go = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    addr = a; we = 0;
    push(0, exp, tag, 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic chk_out(input logic [NC-1:0] exp, input string tag);
    push(1, 32'(exp), tag, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8: reset state with all sources high
    irq = '1;
    rd(8'h00, 0, "R8 cpu0 en slot0");
    rd(8'h04, 0, "R8 cpu0 en slot1");
    rd(8'h10, 0, "R8 cpu1 en slot0");
    rd(8'h14, 0, "R8 cpu1 en slot1");
    chk_out(2'b00, "R8 outputs low");
    // R1 R3 R5: status readback and descending order
    irq = 64'h0000_0005_8000_0001;
    rd(8'h08, 32'h0000_0005, "R3 status slot 2 is group1");
    rd(8'h0C, 32'h8000_0001, "R1 status slot 3 is group0");
    rd(8'h18, 32'h0000_0005, "R2 cpu1 status slot");
    // R5: status write ignored
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h8000_0001, "R5 status unchanged after write");
    rd(8'h04, 0, "R5 no enable written");
    chk_out(2'b00, "R5 no output after status write");
    // R4 R6 R7: enable source 0 for cpu0
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, 32'h0000_0001, "R4 enable readback");
    rd(8'h14, 0, "R7 cpu1 enable untouched");
    chk_out(2'b01, "R7 only cpu0 asserted");
    // cpu1 enables source 34 via group1 slot
    wr(8'h10, 32'h0000_0004);
    chk_out(2'b11, "R6 both asserted");
    // R4: replace, not OR
    wr(8'h04, 32'h0000_0002);
    rd(8'h04, 32'h0000_0002, "R4 word replaced");
    chk_out(2'b10, "R4 cpu0 dropped after replace");
    // R9: unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 0, "R9 unmapped read zero");
    rd(8'h04, 32'h0000_0002, "R9 cpu0 enable unchanged");
    rd(8'h14, 0, "R9 cpu1 enable unchanged");
    chk_out(2'b10, "R9 outputs unchanged");
    // R6 latency: drop source 34, old value same cycle, new one edge later
    @(posedge clk); #1;
    irq = 64'h0000_0001_8000_0003;
    push(1, 32'(2'b10), "R6 output held before edge", 0);
    chk_out(2'b01, "R6 output after one edge");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule